// File: doc/BRIEF.md
# Vectored Nested Interrupt Controller

This block gathers up to 32 interrupt inputs behind a small register bus and drives one interrupt request to the processor. Each input has a mode word and a vector word. The mode word holds a three-bit priority and a trigger kind. The trigger kind is one of high level, low level, rising edge or falling edge. Write-one command words set or clear mask bits, force a source pending, or discard a latched pending state. Each input passes through a two-stage synchronizer before any of this logic sees it.

The processor services an interrupt by reading the vector word. If a source currently qualifies, that read returns the winner's vector. It also records the winner's priority and number on an eight-entry nesting stack and clears the winner's latched pending bit. Only a source that strictly outranks the top of the stack raises the request, so nested handlers are pre-empted only by higher priorities. Writing the end-of-interrupt word pops one level. If nothing qualifies, the vector read returns a programmable spurious value and changes no state.

The bus is word-addressed. Word index = byte offset / 4. Mode words sit at indexes 0x00–0x1F, one per source. Vector words sit at 0x20–0x3F. The control words are:

| Index | Word |
|-------|------|
| 0x40 | vector read / acknowledge |
| 0x42 | current-source status |
| 0x43 | pending |
| 0x44 | mask |
| 0x45 | core status, bit 0 = request |
| 0x48 | enable command |
| 0x49 | disable command |
| 0x4A | clear command |
| 0x4B | set command |
| 0x4C | end-of-interrupt |
| 0x4D | spurious value |

Top module: `vnic_ctrl`

## Requirements
- R1: After reset, the following all read zero: the mask, the pending word, the current-source status, every mode word and every vector word. The request output is low, and a vector read returns zero, which is the reset spurious value.
- R2: A write to the enable command word (index 0x48) sets the mask bits written as one. A write to the disable command word (index 0x49) clears them. Mask bits written as zero are unchanged. The mask reads back at index 0x44.
- R3: A write to the set command word (index 0x4B) latches pending every source written as one. A write to the clear command word (index 0x4A) drops the latch for those sources. The pending word reads at index 0x43. Writing all ones to disable and then to clear leaves the mask and the pending word at zero.
- R4: A mode word keeps only the priority in bits [2:0] (7 is highest) and the trigger kind in bits [6:5]. All other bits read zero. Vector words hold all 32 bits.
- R5: Trigger kind 0 is high level and kind 2 is low level. For these two kinds the pending bit follows the synchronized input. Kind 1 is rising edge and kind 3 is falling edge. For these two kinds an active edge latches the pending bit, and it stays set after the input returns.
- R6: The request output, also readable as bit 0 of index 0x45, is high exactly when a pending, unmasked source exists whose priority is strictly above the priority on top of the nesting stack. Any priority qualifies when the stack is empty.
- R7: Among qualifying sources, the highest priority wins and the lowest source number breaks ties. A vector read returns the winner's vector word.
- R8: A vector read while the request is low returns the spurious value (index 0x4D) and leaves the stack unchanged.
- R9: A vector read while the request is high does three things. It pushes the winner, so the status at index 0x42 shows its number. It clears the winner's latched pending bit. It lowers the request unless another source outranks the winner.
- R10: Each write to the end-of-interrupt word (index 0x4C) pops one stack level, and the status then shows the source below. When the stack is empty the write is ignored. Eight writes empty the stack from any depth.
- R11: The stack holds at most eight levels. The eighth level has priority 7, and a further priority-7 source cannot raise the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_in | input | 32 | Raw interrupt inputs, synchronized inside |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the read cycle |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block at its default size: 32 sources, a stack depth of 8 and three-bit priorities. At this size every source, every priority value and a completely full stack are all within a short run. The bench assigns priorities so that every priority is shared by four sources. It then sweeps forty pending and mask patterns, some chosen to force ties, and predicts the winner, the status and the remaining request arithmetically. One source is taken through all four trigger kinds. The priorities 0 to 7 are then stacked to full depth, checked at the limit, and unwound.

// File: rtl/vnic_pkg.sv
package vnic_pkg;
  localparam int PRIO_W = 3;
  localparam int KIND_W = 2;

  typedef logic [PRIO_W-1:0] prio_t;

  typedef struct packed {
    logic [KIND_W-1:0] kind;   // bit0 = edge sensitive, bit1 = active low
    prio_t             prio;
  } mode_t;

  // word indexes of the control words
  localparam logic [6:0] W_VEC_ACK  = 7'h40;
  localparam logic [6:0] W_CUR_SRC  = 7'h42;
  localparam logic [6:0] W_PENDING  = 7'h43;
  localparam logic [6:0] W_MASK     = 7'h44;
  localparam logic [6:0] W_CORE     = 7'h45;
  localparam logic [6:0] W_EN_CMD   = 7'h48;
  localparam logic [6:0] W_DIS_CMD  = 7'h49;
  localparam logic [6:0] W_CLR_CMD  = 7'h4A;
  localparam logic [6:0] W_SET_CMD  = 7'h4B;
  localparam logic [6:0] W_EOI      = 7'h4C;
  localparam logic [6:0] W_SPUR     = 7'h4D;

  function automatic mode_t mode_from_word(input logic [31:0] w);
    mode_t m;
    m.kind = w[6:5];
    m.prio = w[2:0];
    return m;
  endfunction

  function automatic logic [31:0] mode_to_word(input mode_t m);
    return {25'd0, m.kind, 2'b00, m.prio};
  endfunction

  function automatic logic kind_is_edge(input mode_t m);
    return m.kind[0];
  endfunction

  function automatic logic kind_is_low(input mode_t m);
    return m.kind[1];
  endfunction

  // a candidate qualifies against the nesting stack
  function automatic logic outranks(input logic stack_empty, input prio_t top, input prio_t cand);
    return stack_empty || (cand > top);
  endfunction
endpackage

// File: rtl/vnic_src_bank.sv
module vnic_src_bank
  import vnic_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         src_in,
  input  mode_t [NUM_SRC-1:0]        modes,
  input  logic [NUM_SRC-1:0]         set_bits,
  input  logic [NUM_SRC-1:0]         clr_bits,
  input  logic [NUM_SRC-1:0]         ack_bits,
  output logic [NUM_SRC-1:0]         pend
);
  logic [NUM_SRC-1:0] sync1_q, sync2_q, prev_q, latch_q;
  logic [NUM_SRC-1:0] edge_hit, level_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= src_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic active_now, active_before;
    assign active_now    = sync2_q[g] ^ kind_is_low(modes[g]);
    assign active_before = prev_q[g]  ^ kind_is_low(modes[g]);
    assign edge_hit[g]   = kind_is_edge(modes[g]) && active_now && !active_before;
    assign level_hit[g]  = !kind_is_edge(modes[g]) && active_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= (latch_q & ~clr_bits & ~ack_bits) | set_bits | edge_hit;
  end

  assign pend = latch_q | level_hit;

  // R3: a forced source is latched pending on the following cycle
  p_set_latches_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_bits & ~clr_bits)) |=> ((latch_q & $past(set_bits & ~clr_bits)) == $past(set_bits & ~clr_bits)));
  // R3: a cleared source with no new cause is no longer latched
  p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_bits) && !(|set_bits) && !(|edge_hit) |=> ((latch_q & $past(clr_bits)) == '0));
endmodule

// File: rtl/vnic_arbiter.sv
module vnic_arbiter
  import vnic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  eligible,
  input  mode_t [NUM_SRC-1:0] modes,
  output logic                win_valid,
  output logic [ID_W-1:0]     win_id,
  output prio_t               win_prio
);
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_prio  = '0;
    // ascending scan, strict compare: equal priority keeps the lower number
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && (!win_valid || modes[i].prio > win_prio)) begin
        win_valid = 1'b1;
        win_id    = ID_W'(i);
        win_prio  = modes[i].prio;
      end
    end
  end

  // R7: the winner is always an eligible source
  p_win_eligible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> eligible[win_id]);
  // R7: a winner exists whenever anything is eligible
  p_win_present_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|eligible) |-> win_valid);
endmodule

// File: rtl/vnic_nest_stack.sv
module vnic_nest_stack
  import vnic_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ID_W  = 5,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  prio_t            push_prio,
  input  logic [ID_W-1:0]  push_id,
  input  logic             pop,
  output logic             empty,
  output prio_t            top_prio,
  output logic [ID_W-1:0]  top_id,
  output logic [CNT_W-1:0] count
);
  prio_t            prio_q [DEPTH];
  logic [ID_W-1:0]  id_q   [DEPTH];
  logic [CNT_W-1:0] count_q, below_c;
  logic [IDX_W-1:0] top_idx, wr_idx;
  logic             full;

  assign empty   = (count_q == '0);
  assign full    = (count_q == CNT_W'(DEPTH));
  assign below_c = count_q - CNT_W'(1);
  assign top_idx = below_c[IDX_W-1:0];
  assign wr_idx  = count_q[IDX_W-1:0];
  assign count   = count_q;
  assign top_prio = empty ? '0 : prio_q[top_idx];
  assign top_id   = empty ? '0 : id_q[top_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        prio_q[i] <= '0;
        id_q[i]   <= '0;
      end
    end else if (push && !full) begin
      prio_q[wr_idx] <= push_prio;
      id_q[wr_idx]   <= push_id;
      count_q        <= count_q + CNT_W'(1);
    end else if (pop && !empty) begin
      count_q <= below_c;
    end
  end

  // R11: depth never exceeds the limit
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));
  // R11: arbitration never asks for a push into a full stack
  p_push_not_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R9: a pushed entry becomes the new top
  p_push_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (top_id == $past(push_id)) && (top_prio == $past(push_prio)));
  // R10: a pop on an empty stack is ignored
  p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> empty);
endmodule

// File: rtl/vnic_ctrl.sv
module vnic_ctrl
  import vnic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DEPTH   = 8,
  localparam int ID_W   = $clog2(NUM_SRC),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SLOT_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [6:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o
);
  mode_t [NUM_SRC-1:0] mode_q;
  logic  [31:0]        vec_q [NUM_SRC];
  logic  [NUM_SRC-1:0] mask_q;
  logic  [31:0]        spur_q;

  // named bus events
  logic wr_hit, rd_hit, en_wr, dis_wr, clr_wr, set_wr, eoi_wr, spur_wr, vec_rd;
  logic mode_wr, vword_wr;
  logic [SLOT_W-1:0] slot;

  assign wr_hit   = bus_sel && bus_we;
  assign rd_hit   = bus_sel && !bus_we;
  assign slot     = bus_addr[SLOT_W-1:0];
  assign mode_wr  = wr_hit && (bus_addr[6:5] == 2'b00);
  assign vword_wr = wr_hit && (bus_addr[6:5] == 2'b01);
  assign en_wr    = wr_hit && (bus_addr == W_EN_CMD);
  assign dis_wr   = wr_hit && (bus_addr == W_DIS_CMD);
  assign clr_wr   = wr_hit && (bus_addr == W_CLR_CMD);
  assign set_wr   = wr_hit && (bus_addr == W_SET_CMD);
  assign eoi_wr   = wr_hit && (bus_addr == W_EOI);
  assign spur_wr  = wr_hit && (bus_addr == W_SPUR);
  assign vec_rd   = rd_hit && (bus_addr == W_VEC_ACK);

  // pending, arbitration, stack
  logic [NUM_SRC-1:0] pend, eligible, set_bits, clr_bits, ack_bits;
  logic               win_valid, stk_empty, push;
  logic [ID_W-1:0]    win_id, top_id;
  prio_t              win_prio, top_prio;
  logic [CNT_W-1:0]   stk_count;

  assign set_bits = set_wr ? bus_wdata[NUM_SRC-1:0] : '0;
  assign clr_bits = clr_wr ? bus_wdata[NUM_SRC-1:0] : '0;
  assign eligible = pend & mask_q;
  assign irq_o    = win_valid && outranks(stk_empty, top_prio, win_prio);
  assign push     = vec_rd && irq_o;
  assign ack_bits = push ? (NUM_SRC'(1) << win_id) : '0;

  vnic_src_bank #(.NUM_SRC(NUM_SRC)) bank_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .modes(mode_q),
    .set_bits(set_bits), .clr_bits(clr_bits), .ack_bits(ack_bits), .pend(pend)
  );

  vnic_arbiter #(.NUM_SRC(NUM_SRC)) arb_i (
    .clk(clk), .rst_n(rst_n), .eligible(eligible), .modes(mode_q),
    .win_valid(win_valid), .win_id(win_id), .win_prio(win_prio)
  );

  vnic_nest_stack #(.DEPTH(DEPTH), .ID_W(ID_W)) stack_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_prio(win_prio), .push_id(win_id),
    .pop(eoi_wr), .empty(stk_empty), .top_prio(top_prio), .top_id(top_id),
    .count(stk_count)
  );

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      spur_q <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        mode_q[i] <= '0;
        vec_q[i]  <= '0;
      end
    end else begin
      if (en_wr)   mask_q <= mask_q | bus_wdata[NUM_SRC-1:0];
      if (dis_wr)  mask_q <= mask_q & ~bus_wdata[NUM_SRC-1:0];
      if (spur_wr) spur_q <= bus_wdata;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (mode_wr  && slot == SLOT_W'(i)) mode_q[i] <= mode_from_word(bus_wdata);
        if (vword_wr && slot == SLOT_W'(i)) vec_q[i]  <= bus_wdata;
      end
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      if (bus_addr[6:5] == 2'b00) begin
        for (int i = 0; i < NUM_SRC; i++)
          if (slot == SLOT_W'(i)) bus_rdata = mode_to_word(mode_q[i]);
      end else if (bus_addr[6:5] == 2'b01) begin
        for (int i = 0; i < NUM_SRC; i++)
          if (slot == SLOT_W'(i)) bus_rdata = vec_q[i];
      end else begin
        case (bus_addr)
          W_VEC_ACK: bus_rdata = irq_o ? vec_q[win_id] : spur_q;
          W_CUR_SRC: bus_rdata = 32'(top_id);
          W_PENDING: bus_rdata = 32'(pend);
          W_MASK:    bus_rdata = 32'(mask_q);
          W_CORE:    bus_rdata = {31'd0, irq_o};
          W_SPUR:    bus_rdata = spur_q;
          default:   bus_rdata = '0;
        endcase
      end
    end
  end

  // R2: enabled bits are set on the next cycle
  p_mask_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));
  // R2: disabled bits are cleared on the next cycle
  p_mask_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));
  // R6: a request always has an unmasked pending source behind it
  p_irq_has_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(pend & mask_q)));
  // R8: a vector read without a request leaves the stack depth alone
  p_spurious_no_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !irq_o) |=> (stk_count == $past(stk_count)));
  // R10: end-of-interrupt on a non-empty stack removes exactly one level
  p_eoi_pops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !stk_empty) |=> (stk_count == $past(stk_count) - CNT_W'(1)));
endmodule

// File: tb/vnic_ctrl_tb.sv
`timescale 1ns/1ps
module vnic_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vnic_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  localparam logic [6:0] A_VEC = 7'h40, A_CUR = 7'h42, A_PEND = 7'h43, A_MASK = 7'h44,
    A_CORE = 7'h45, A_EN = 7'h48, A_DIS = 7'h49, A_CLR = 7'h4A, A_SET = 7'h4B,
    A_EOI = 7'h4C, A_SPUR = 7'h4D;
  localparam logic [31:0] SPUR = 32'hDEAD_0F0F;

  function automatic logic [31:0] vecval(input int i);
    return 32'hA000_0005 | (32'(i) << 4);
  endfunction
  function automatic int sweep_prio(input int i);
    return (i * 5 + 3) % 8;
  endfunction
  function automatic int best_of(input logic [31:0] e);
    for (int p = 7; p >= 0; p--)
      for (int i = 0; i < 32; i++)
        if (e[i] && sweep_prio(i) == p) return i;
    return -1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d, acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_MASK, d); chk("R1 mask", d, 0);
    rd(A_PEND, d); chk("R1 pending", d, 0);
    rd(A_CUR, d);  chk("R1 status", d, 0);
    rd(7'h03, d);  chk("R1 mode", d, 0);
    rd(7'h27, d);  chk("R1 vector", d, 0);
    chk("R1 irq", 32'(irq_o), 0);
    rd(A_VEC, d);  chk("R1 spurious reset", d, 0);

    // R2 mask commands
    wr(A_EN, 32'hF0F0_1234);  rd(A_MASK, d); chk("R2 enable", d, 32'hF0F0_1234);
    wr(A_EN, 32'h0000_8000);  rd(A_MASK, d); chk("R2 enable or", d, 32'hF0F0_9234);
    wr(A_DIS, 32'h00F0_1200); rd(A_MASK, d); chk("R2 disable", d, 32'hF000_8034);

    // R4 mode and vector words over all sources
    for (int i = 0; i < 32; i++) begin
      wr(7'(i), 32'hFFFF_FF80 | 32'(i % 8) | (32'(i % 4) << 5) | 32'h18);
      wr(7'(32 + i), vecval(i));
    end
    for (int i = 0; i < 32; i++) begin
      rd(7'(i), d); chk("R4 mode fields", d, 32'(i % 8) | (32'(i % 4) << 5));
      rd(7'(32 + i), d); chk("R4 vector word", d, vecval(i));
    end
    for (int i = 0; i < 32; i++) wr(7'(i), 32'(sweep_prio(i)));

    // R3 set / clear, disable+clear all
    wr(A_DIS, '1); wr(A_CLR, '1);
    acc = 0;
    for (int i = 0; i < 32; i++) begin
      wr(A_SET, 32'h1 << i); acc |= 32'h1 << i;
      rd(A_PEND, d); chk("R3 set accumulates", d, acc);
    end
    wr(A_CLR, 32'h5555_5555); rd(A_PEND, d); chk("R3 clear ones only", d, 32'hAAAA_AAAA);
    wr(A_EN, '1); wr(A_DIS, '1); wr(A_CLR, '1);
    rd(A_MASK, d); chk("R3 all masked", d, 0);
    rd(A_PEND, d); chk("R3 none pending", d, 0);

    // R5 trigger kinds on source 5
    src_in[5] = 1'b1; wait_clk(5); rd(A_PEND, d); chk("R5 level high on", d, 32'h20);
    src_in[5] = 1'b0; wait_clk(5); rd(A_PEND, d); chk("R5 level high off", d, 0);
    wr(7'd5, 32'h20 | 32'(sweep_prio(5)));
    src_in[5] = 1'b1; wait_clk(5); rd(A_PEND, d); chk("R5 rising latched", d, 32'h20);
    src_in[5] = 1'b0; wait_clk(5); rd(A_PEND, d); chk("R5 rising held", d, 32'h20);
    wr(A_CLR, 32'h20); rd(A_PEND, d); chk("R5 rising cleared", d, 0);
    wr(7'd5, 32'h60 | 32'(sweep_prio(5)));
    src_in[5] = 1'b1; wait_clk(5); rd(A_PEND, d); chk("R5 falling ignores rise", d, 0);
    src_in[5] = 1'b0; wait_clk(5); rd(A_PEND, d); chk("R5 falling latched", d, 32'h20);
    wr(A_CLR, 32'h20);
    wr(7'd5, 32'h40 | 32'(sweep_prio(5)));
    rd(A_PEND, d); chk("R5 level low active", d, 32'h20);
    src_in[5] = 1'b1; wait_clk(5); rd(A_PEND, d); chk("R5 level low idle", d, 0);
    wr(7'd5, 32'(sweep_prio(5)));
    src_in[5] = 1'b0; wait_clk(5);

    // R6 R7 R9 arbitration sweep
    wr(A_SPUR, SPUR);
    for (int it = 0; it < 40; it++) begin
      logic [31:0] pat, h, dbit, elig;
      int w;
      bit more;
      if (it < 16) pat = (32'h1 << it) | (32'h1 << ((it + 8) % 32));
      else begin h = 32'(it) * 32'h9E37_79B1; pat = h ^ (h >> 13); end
      dbit = 32'h1 << ((it * 7) % 32);
      elig = pat & ~dbit;
      w = best_of(elig);
      wr(A_CLR, '1); wr(A_EN, '1); wr(A_DIS, dbit); wr(A_SET, pat);
      chk("R6 irq raised", 32'(irq_o), (w >= 0) ? 1 : 0);
      rd(A_CORE, d); chk("R6 core status", d, (w >= 0) ? 1 : 0);
      rd(A_VEC, d); chk("R7 winner vector", d, (w >= 0) ? vecval(w) : SPUR);
      rd(A_CUR, d); chk("R9 status shows winner", d, (w >= 0) ? 32'(w) : 0);
      rd(A_PEND, d); chk("R9 ack clears latch", d, (w >= 0) ? (pat & ~(32'h1 << w)) : pat);
      more = 0;
      if (w >= 0)
        for (int j = 0; j < 32; j++)
          if (elig[j] && j != w && sweep_prio(j) > sweep_prio(w)) more = 1;
      chk("R9 irq after ack", 32'(irq_o), 32'(more));
      wr(A_EOI, 0);
      rd(A_CUR, d); chk("R10 status after pop", d, 0);
    end

    // R8 spurious with nothing pending
    wr(A_CLR, '1);
    rd(A_VEC, d); chk("R8 spurious value", d, SPUR);
    chk("R8 no request", 32'(irq_o), 0);
    wr(A_EOI, 0);
    rd(A_CUR, d); chk("R8 no push", d, 0);

    // R10 R11 nesting
    wr(A_EN, '1);
    for (int i = 0; i < 32; i++) wr(7'(i), (i < 8) ? 32'(i) : 32'd0);
    for (int k = 0; k < 8; k++) begin
      wr(A_SET, 32'h1 << k);
      chk("R6 nested request", 32'(irq_o), 1);
      rd(A_VEC, d); chk("R7 nested vector", d, vecval(k));
      rd(A_CUR, d); chk("R9 nested status", d, 32'(k));
    end
    wr(A_SET, 32'h80);
    chk("R11 full stack blocks equal priority", 32'(irq_o), 0);
    rd(A_VEC, d); chk("R8 spurious at full depth", d, SPUR);
    rd(A_CUR, d); chk("R11 top unchanged", d, 7);
    for (int e = 1; e <= 8; e++) begin
      wr(A_EOI, 0);
      rd(A_CUR, d); chk("R10 unwind status", d, (e < 8) ? 32'(7 - e) : 0);
      if (e == 1) chk("R6 request after pop", 32'(irq_o), 1);
    end
    wr(A_EOI, 0);
    rd(A_CUR, d); chk("R10 pop on empty ignored", d, 0);
    chk("R10 request on empty stack", 32'(irq_o), 1);
    rd(A_VEC, d); chk("R7 source 7 vector", d, vecval(7));
    for (int e = 0; e < 8; e++) wr(A_EOI, 0);
    rd(A_CUR, d); chk("R10 eight pops empty", d, 0);
    wr(A_SET, 32'h1);
    chk("R10 lowest priority requests on empty stack", 32'(irq_o), 1);
    rd(A_VEC, d); chk("R7 source 0 vector", d, vecval(0));
    wr(A_EOI, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule